// File: doc/BRIEF.md
# Keyed Tone and Loop Current Signaller

This block turns a 7-bit key code into the line signals that announce one key to the exchange. While a key is being sent, it drives a square-wave tone, an identification-control level and three loop-current selects. The tone is one of twenty fixed frequencies, and the frequencies do not rise steadily with the code. The current selects are handset-off (active low), M-key and C-key. The two upper code bits pick the current class. The low five bits pick either a tone digit or one of the special no-tone pulses.

A send starts on a one-cycle strobe. It lasts at least a parameterised hold time, even if the key is let go at once. It stretches for as long as the key-down level stays high. A second key that arrives during a send waits in a single slot and starts on the cycle after the current send ends. When entering M-key current, the C-key select is also driven for a short speed-up window, so the exchange detects the new level sooner. When idle in display mode, the tone pin shows the position of the open/private switch.

Top module: `tls_signaller`

## Requirements
- R1: For a code whose low five bits n are 0..19, the tone toggles with half period floor(CLK_HZ/(2*f)). Codes 0..9 use f = 500+200*n Hz. Codes 10..19 use, in order, 400, 2600, 450, 2900, 600, 3200, 800, 3600, 1000 and 4000 Hz. The tone is high in the first active cycle, and its counter restarts at every new key.
- R2: Code bits 6:5 set the current class. Value 0 asserts no current output (handset-on). Value 1 drives `m_cur_o` high. Value 2 drives `hs_cur_n_o` low.
- R3: Low bits 20 give an identification pulse with the tone held low. Low bits 21..30 give a current pulse only, with tone and identification low. Low bits 31 drive only `c_cur_o`, whatever the class.
- R4: `id_ctl_o` is high for every active cycle of a code with low bits 0..20, and low otherwise.
- R5: A send is active from the cycle after the strobe edge. With `key_down_i` low it lasts exactly HOLD cycles, where HOLD = CLK_HZ/1000*HOLD_MS. If `key_down_i` is still high when HOLD has elapsed, the send ends on the first edge that samples it low.
- R6: Outside the speed-up window, at most one current output is asserted. An M-key current send also drives `c_cur_o` for its first BOOST = CLK_HZ/1000*BOOST_MS cycles.
- R7: While idle, the current outputs are inactive, `id_ctl_o` is low, and `tone_o` equals `display_mode_i & private_sw_i`.
- R8: A valid strobe during a send is stored in one slot and becomes active on the cycle after that send ends. A strobe while the slot is full is ignored.
- R9: A strobe with code bits 6:5 equal to 3 is ignored, whether the block is idle or busy.
- R10: After reset the block is idle, with the outputs given in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_strobe_i | input | 1 | One-cycle request to send `key_code_i` |
| key_code_i | input | 7 | Key code: class in bits 6:5, digit/pulse in 4:0 |
| key_down_i | input | 1 | Key still pressed; stretches the send past the hold time |
| display_mode_i | input | 1 | High in display-station mode |
| private_sw_i | input | 1 | Open/private switch, high for PRIVATE |
| tone_o | output | 1 | Digit tone, or the idle switch level |
| id_ctl_o | output | 1 | Identification control, high while a digit is sent |
| hs_cur_n_o | output | 1 | Handset-off current select, active low |
| m_cur_o | output | 1 | M-key current select, active high |
| c_cur_o | output | 1 | C-key current select, active high |

## Verification
The checker watches every cycle for the following properties:
- the idle output levels;
- no send shorter than the hold time;
- exclusive current selects, with the C/M overlap capped at the speed-up length;
- identification held high whenever the tone moves within a send.

The bench's own scenarios are needed for the rest:
- the exact half period of each of the twenty tones;
- the class and special-pulse decoding;
- the exact end cycle when the key is released late;
- the launch cycle of a queued key;
- dropping a third key while the slot is full;
- rejection of class-3 codes.

// File: rtl/tls_pkg.sv
package tls_pkg;

    typedef enum logic [1:0] {
        CUR_NONE  = 2'd0,
        CUR_MKEY  = 2'd1,
        CUR_HSOFF = 2'd2,
        CUR_CKEY  = 2'd3
    } cur_e;

    // Full decode of one key code
    typedef struct packed {
        logic       ok;
        logic       tone;
        logic [4:0] idx;
        logic       id;
        cur_e       cur;
    } key_info_t;

    // Part of the decode kept for the key in flight
    typedef struct packed {
        logic tone;
        logic id;
        cur_e cur;
    } act_t;

    // Tone frequency in Hz for digit index 0..19
    function automatic int unsigned tone_hz(int unsigned idx);
        case (idx)
            10: return 400;
            11: return 2600;
            12: return 450;
            13: return 2900;
            14: return 600;
            15: return 3200;
            16: return 800;
            17: return 3600;
            18: return 1000;
            19: return 4000;
            default: return 500 + 200 * idx;
        endcase
    endfunction

endpackage

// File: rtl/tls_key_decode.sv
module tls_key_decode
    import tls_pkg::*;
(
    input  logic [6:0] code_i,
    output key_info_t  info_o
);
    logic [1:0] grp;
    logic [4:0] low;

    assign grp = code_i[6:5];
    assign low = code_i[4:0];

    always_comb begin
        info_o      = '0;
        info_o.ok   = (grp != 2'd3);
        info_o.idx  = low;
        info_o.tone = (low < 5'd20);
        info_o.id   = (low <= 5'd20);
        if (low == 5'd31) begin
            info_o.cur = CUR_CKEY;
        end else begin
            case (grp)
                2'd1:    info_o.cur = CUR_MKEY;
                2'd2:    info_o.cur = CUR_HSOFF;
                default: info_o.cur = CUR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/tls_half_lut.sv
module tls_half_lut #(
    parameter int unsigned CLK_HZ = 100_000,
    parameter int unsigned HALF_W = 8
) (
    input  logic [4:0]        idx_i,
    output logic [HALF_W-1:0] half_o
);
    logic [HALF_W-1:0] lut [32];

    // Entries are constants computed at elaboration from the clock rate
    for (genvar g = 0; g < 32; g++) begin : g_ent
        if (g < 20) begin : g_tone
            assign lut[g] = HALF_W'(CLK_HZ / (2 * tls_pkg::tone_hz(g)));
        end else begin : g_none
            assign lut[g] = '0;
        end
    end

    assign half_o = lut[idx_i];

endmodule

// File: rtl/tls_tone_gen.sv
module tls_tone_gen #(
    parameter int unsigned HALF_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              restart_i,
    input  logic              run_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              phase_o
);
    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic [HALF_W-1:0] half;
        logic              ph;
    } tg_st_t;

    tg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.half = half_i;
            st_d.cnt  = half_i - ONE;
            st_d.ph   = 1'b1;
        end else if (run_i) begin
            if (st_q.cnt == '0) begin
                st_d.ph  = ~st_q.ph;
                st_d.cnt = st_q.half - ONE;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign phase_o = st_q.ph;

endmodule

// File: rtl/tls_signaller.sv
module tls_signaller
    import tls_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 100_000,
    parameter int unsigned HOLD_MS  = 5,
    parameter int unsigned BOOST_MS = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       key_strobe_i,
    input  logic [6:0] key_code_i,
    input  logic       key_down_i,
    input  logic       display_mode_i,
    input  logic       private_sw_i,
    output logic       tone_o,
    output logic       id_ctl_o,
    output logic       hs_cur_n_o,
    output logic       m_cur_o,
    output logic       c_cur_o
);
    localparam int unsigned HOLD_CYC  = CLK_HZ / 1000 * HOLD_MS;
    localparam int unsigned BOOST_CYC = CLK_HZ / 1000 * BOOST_MS;
    localparam int unsigned HALF_W    = $clog2(CLK_HZ / 800 + 1);
    localparam int unsigned HOLD_W    = $clog2(HOLD_CYC + 1);
    localparam int unsigned BOOST_W   = $clog2(BOOST_CYC + 1);

    typedef struct packed {
        logic               busy;
        act_t               act;
        logic [HOLD_W-1:0]  hold;
        logic [BOOST_W-1:0] boost;
        logic               pend_v;
        logic [6:0]         pend_code;
    } sig_st_t;

    sig_st_t st_d, st_q;

    logic              ending, can_launch, new_ok;
    logic              use_pend, use_new, launch;
    logic [6:0]        src_code;
    key_info_t         src_info;
    logic [HALF_W-1:0] src_half;
    logic              tone_ph;

    // The queued key, when present, has priority over a fresh strobe
    assign src_code = st_q.pend_v ? st_q.pend_code : key_code_i;

    tls_key_decode i_dec (
        .code_i (src_code),
        .info_o (src_info)
    );

    tls_half_lut #(
        .CLK_HZ (CLK_HZ),
        .HALF_W (HALF_W)
    ) i_lut (
        .idx_i  (src_info.idx),
        .half_o (src_half)
    );

    tls_tone_gen #(
        .HALF_W (HALF_W)
    ) i_tone (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (launch),
        .run_i     (st_q.busy && st_q.act.tone),
        .half_i    (src_half),
        .phase_o   (tone_ph)
    );

    always_comb begin
        ending     = st_q.busy && (st_q.hold == '0) && !key_down_i;
        can_launch = !st_q.busy || ending;
        new_ok     = key_strobe_i && (key_code_i[6:5] != 2'b11);
        use_pend   = can_launch && st_q.pend_v;
        use_new    = can_launch && !st_q.pend_v && key_strobe_i && src_info.ok;
        launch     = use_pend || use_new;

        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.hold != '0)  st_d.hold  = st_q.hold - HOLD_W'(1);
            if (st_q.boost != '0) st_d.boost = st_q.boost - BOOST_W'(1);
        end
        if (ending && !launch) begin
            st_d.busy = 1'b0;
        end
        if (launch) begin
            st_d.busy     = 1'b1;
            st_d.act.tone = src_info.tone;
            st_d.act.id   = src_info.id;
            st_d.act.cur  = src_info.cur;
            st_d.hold     = HOLD_W'(HOLD_CYC - 1);
            st_d.boost    = (src_info.cur == CUR_MKEY) ? BOOST_W'(BOOST_CYC) : '0;
        end
        if (use_pend) begin
            st_d.pend_v = 1'b0;
        end
        // Fill the slot only when it is free after this cycle
        if (new_ok && !use_new && (!st_q.pend_v || use_pend)) begin
            st_d.pend_v    = 1'b1;
            st_d.pend_code = key_code_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tone_o     = st_q.busy ? (st_q.act.tone && tone_ph)
                                  : (display_mode_i && private_sw_i);
    assign id_ctl_o   = st_q.busy && st_q.act.id;
    assign hs_cur_n_o = !(st_q.busy && (st_q.act.cur == CUR_HSOFF));
    assign m_cur_o    = st_q.busy && (st_q.act.cur == CUR_MKEY);
    assign c_cur_o    = st_q.busy && ((st_q.act.cur == CUR_CKEY) || (st_q.boost != '0));

endmodule

// File: rtl/tls_checker.sv
module tls_checker #(
    parameter int unsigned HOLD_CYC  = 500,
    parameter int unsigned BOOST_CYC = 100
) (
    input logic clk_i,
    input logic rst_ni,
    input logic busy_i,
    input logic tone_i,
    input logic id_i,
    input logic hs_n_i,
    input logic m_i,
    input logic c_i,
    input logic disp_i,
    input logic priv_i
);
    int unsigned run_q, mc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= 0;
            mc_q  <= 0;
        end else begin
            run_q <= busy_i ? run_q + 1 : 0;
            mc_q  <= (m_i && c_i) ? mc_q + 1 : 0;
        end
    end

    p_hold_min_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_i) |-> run_q >= HOLD_CYC);

    p_single_cur_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(m_i && c_i) |-> $onehot0({!hs_n_i, m_i, c_i}));

    p_boost_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_i && c_i) |-> (hs_n_i && mc_q < BOOST_CYC));

    p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i |-> (hs_n_i && !m_i && !c_i && !id_i && tone_i == (disp_i && priv_i)));

    p_id_with_tone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && $past(busy_i) && !$stable(tone_i) && $stable(id_i)) |-> id_i);

endmodule

bind tls_signaller tls_checker #(
    .HOLD_CYC  (HOLD_CYC),
    .BOOST_CYC (BOOST_CYC)
) i_tls_checker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (st_q.busy),
    .tone_i (tone_o),
    .id_i   (id_ctl_o),
    .hs_n_i (hs_cur_n_o),
    .m_i    (m_cur_o),
    .c_i    (c_cur_o),
    .disp_i (display_mode_i),
    .priv_i (private_sw_i)
);

// File: tb/test_tls_signaller.sv
module test_tls_signaller;
    localparam int CLK_HZ   = 100_000;
    localparam int HOLD_MS  = 5;
    localparam int BOOST_MS = 1;
    localparam int HOLD     = CLK_HZ / 1000 * HOLD_MS;
    localparam int BOOST    = CLK_HZ / 1000 * BOOST_MS;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       strobe = 1'b0, kdown = 1'b0, disp = 1'b0, priv = 1'b0;
    logic [6:0] code = '0;
    logic       tone, id, hs_n, m, c;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    tls_signaller #(
        .CLK_HZ   (CLK_HZ),
        .HOLD_MS  (HOLD_MS),
        .BOOST_MS (BOOST_MS)
    ) i_tls_signaller (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .key_strobe_i   (strobe),
        .key_code_i     (code),
        .key_down_i     (kdown),
        .display_mode_i (disp),
        .private_sw_i   (priv),
        .tone_o         (tone),
        .id_ctl_o       (id),
        .hs_cur_n_o     (hs_n),
        .m_cur_o        (m),
        .c_cur_o        (c)
    );

    function automatic int hz(int low);
        int tbl[10] = '{400, 2600, 450, 2900, 600, 3200, 800, 3600, 1000, 4000};
        if (low < 10) return 500 + 200 * low;
        return tbl[low - 10];
    endfunction

    function automatic int half(int low);
        return CLK_HZ / (2 * hz(low));
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected outputs t cycles into the send of key k
    task automatic expect_active(logic [6:0] k, int t);
        int  grp = int'(k[6:5]);
        int  low = int'(k[4:0]);
        bit  e_tone = (low < 20) ? (((t / half((low < 20) ? low : 0)) % 2) == 0) : 1'b0;
        bit  e_id   = (low <= 20);
        bit  e_m    = (grp == 1) && (low != 31);
        bit  e_c    = (low == 31) || (e_m && t < BOOST);
        bit  e_hsn  = !((grp == 2) && (low != 31));
        chk(tone == e_tone, (low < 20) ? "R1" : "R3", "tone", int'(tone), int'(e_tone));
        chk(id == e_id, "R4", "id_ctl", int'(id), int'(e_id));
        chk(m == e_m, (low == 31) ? "R3" : "R2", "m_cur", int'(m), int'(e_m));
        chk(hs_n == e_hsn, (low == 31) ? "R3" : "R2", "hs_cur_n", int'(hs_n), int'(e_hsn));
        chk(c == e_c, e_m ? "R6" : "R3", "c_cur", int'(c), int'(e_c));
    endtask

    task automatic expect_idle(string req);
        bit e_t = disp && priv;
        chk(tone == e_t, req, "idle tone", int'(tone), int'(e_t));
        chk(id == 1'b0, req, "idle id_ctl", int'(id), 0);
        chk({hs_n, m, c} == 3'b100, req, "idle currents", int'({hs_n, m, c}), 4);
    endtask

    // Send one key; key_down is dropped at sample index rel (-1: never held)
    task automatic send(logic [6:0] k, int rel, string end_req);
        int len = (rel + 1 > HOLD) ? rel + 1 : HOLD;
        @(negedge clk);
        code = k; strobe = 1'b1; kdown = (rel >= 0);
        @(negedge clk);
        strobe = 1'b0;
        for (int t = 0; t < len; t++) begin
            if (t > 0) @(negedge clk);
            if (t == rel) kdown = 1'b0;
            expect_active(k, t);
        end
        @(negedge clk);
        expect_idle(end_req);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R5 watchdog expired: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5171));

        // R10: reset state, idle tone with display+private
        disp = 1'b1; priv = 1'b1;
        repeat (3) @(negedge clk);
        expect_idle("R10");
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R10");

        // R7: idle tone follows switch only in display mode
        for (int i = 0; i < 4; i++) begin
            disp = i[1]; priv = i[0];
            @(negedge clk);
            expect_idle("R7");
        end

        // R1: every tone digit in the handset-on class
        for (int n = 0; n < 20; n++) send(7'(n), -1, "R5");

        // R9: class-3 codes never start a send
        @(negedge clk); code = 7'h65; strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            expect_idle("R9");
        end

        // R3: identification, current-only and C-key pulses in each class
        send(7'h14, -1, "R3");
        send(7'h15, -1, "R3");
        send(7'h1E, -1, "R3");
        send(7'h1F, -1, "R3");
        send(7'h34, -1, "R3");
        send(7'h3F, -1, "R3");
        send(7'h54, -1, "R3");
        send(7'h5F, -1, "R3");

        // R6: M-key class with speed-up; R2 handset-off class
        send(7'h23, -1, "R6");
        send(7'h4B, -1, "R2");

        // R5: early release still holds; late release stretches
        send(7'h06, 3, "R5");
        send(7'h07, HOLD + 37, "R5");
        send(7'h2C, HOLD - 1, "R5");

        // R8: queued key, a third key dropped while slot full, R9 while busy
        @(negedge clk); code = 7'h02; strobe = 1'b1; kdown = 1'b0;
        for (int t = 0; t <= 2 * HOLD; t++) begin
            @(negedge clk);
            strobe = 1'b0;
            if (t < HOLD) expect_active(7'h02, t);
            else if (t < 2 * HOLD) expect_active(7'h45, t - HOLD);
            else expect_idle("R8");
            if (t == 5)  begin code = 7'h45; strobe = 1'b1; end
            if (t == 20) begin code = 7'h11; strobe = 1'b1; end
            if (t == HOLD + 3) begin code = 7'h70; strobe = 1'b1; end
        end
        chk(1'b1, "R8", "queue sequence done", 1, 1);

        // R8: strobe in the final cycle of a send launches straight after
        @(negedge clk); code = 7'h09; strobe = 1'b1;
        for (int t = 0; t <= 2 * HOLD; t++) begin
            @(negedge clk);
            strobe = 1'b0;
            if (t < HOLD) expect_active(7'h09, t);
            else if (t < 2 * HOLD) expect_active(7'h33, t - HOLD);
            else expect_idle("R8");
            if (t == HOLD - 1) begin code = 7'h33; strobe = 1'b1; end
        end

        // Random keys, release times and switch levels
        for (int i = 0; i < 40; i++) begin
            logic [6:0] k;
            int rel;
            k    = {2'($urandom % 3), 5'($urandom % 32)};
            rel  = ($urandom % 2) ? int'($urandom % (HOLD + 60)) : -1;
            disp = 1'($urandom); priv = 1'($urandom);
            send(k, rel, "R5");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule